// File: doc/BRIEF.md
# Configurable Dual Multiply-Add Datapath

This block is a fully registered multiply unit built around two small multipliers, called top and bottom. A static mode parameter decides how their results are used. The two products can be returned separately. They can be added, or the top product can be subtracted from the bottom one. The bottom operands can instead be joined into one wide addend for the top product. In systolic use, the top product is taken one sample later than the bottom product, which lines up taps along a filter chain. In the last mode the two multipliers act as one wide multiplier. Each of the four operands has its own signed or unsigned setting, fixed when the block is instantiated.

Operands are captured in an input register stage and the result is captured in an output register stage. A result therefore appears on the outputs two clock edges after its operands were presented. The run-time `sub` input chooses between add and subtract in the modes that combine two products. Callers that need a narrower addend in addend mode supply it already sign-extended across the two bottom buses.

Top module: `dmadd_unit`

## Requirements
- R1: While `rst_n` is low, `resulta` and `resultb` are zero and the registered `sub` is low. After release, the first results come from all-zero operands.
- R2: Independent mode (`MODE = DM_INDEP`): `resulta` = ax·ay and `resultb` = bx·by. Each product is sign- or zero-extended to its output width according to its operands' settings.
- R3: Sum mode (`MODE = DM_SUM2`): `resulta` = bx·by + ax·ay when `sub` is 0, and `resulta` = bx·by − ax·ay when `sub` is 1. `sub` is taken in the same cycle as the operands.
- R4: In every mode other than independent, `resultb` stays zero.
- R5: Outside wide mode, x operands use bits [17:0]. A y operand uses bits [18:0] when signed and bits [17:0] when unsigned. Bits above these have no effect. A signed operand is extended from its highest used bit.
- R6: Addend mode (`MODE = DM_PLUS36`): `resulta` = ax·ay + A, where A = {bx[17:0], by[17:0]} read as a 36-bit value, signed when bx is set signed. `by[18]` and `sub` have no effect. For example, ax = 0 with bx = 18'h3FFFF and by = 18'h3FAAA gives −1366.
- R7: Systolic mode (`MODE = DM_SYSTOLIC`): `resulta` = bx·by ± ax'·ay'. Here ax' and ay' are the top operands presented one cycle before bx and by. `sub` is taken with the bottom operands and, as in R3, selects subtraction of the top product.
- R8: Wide mode (`MODE = DM_WIDE`): `resulta` = ax[26:0]·ay[26:0], each operand extended according to its own setting. bx, by and `sub` have no effect.
- R9: Operands presented before clock edge k produce their result after edge k+1, so latency is two cycles. Inputs held steady keep the outputs steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| ax | input | 27 | Top x operand |
| ay | input | 27 | Top y operand |
| bx | input | 18 | Bottom x operand, or high half of the addend |
| by | input | 19 | Bottom y operand, or low half of the addend |
| sub | input | 1 | Run-time control: 1 subtracts the top product |
| resulta | output | RA_W (64) | Main result |
| resultb | output | RB_W (37) | Bottom product in independent mode, otherwise zero |

## Verification
Six instances are driven from the same input buses and cover every mode and several signedness mixes. Boundary patterns are applied: all zeros, all ones, the most negative value at each operand's used width, and operands with junk above the used bits. These separate sign extension from zero extension and show whether the per-operand width limits hold. Runs of random operands with `sub` toggling every cycle separate the add and subtract paths. They also expose the one-cycle skew of the systolic top path, because each cycle's operands differ from the previous cycle's. An explicit narrow-addend case and a reset applied mid-run check the addend join and the return to zero.

// File: rtl/dmadd_pkg.sv
package dmadd_pkg;

  localparam int DM_XN_W  = 18;  // small x operand width
  localparam int DM_YN_W  = 19;  // small y operand width (signed)
  localparam int DM_YU_W  = 18;  // small y operand width (unsigned)
  localparam int DM_WD_W  = 27;  // wide operand width
  localparam int DM_ADD_W = 2 * DM_XN_W;  // joined addend width
  localparam int DM_ACC_W = 64;  // internal sum width

  typedef enum logic [2:0] {
    DM_INDEP    = 3'd0,
    DM_SUM2     = 3'd1,
    DM_PLUS36   = 3'd2,
    DM_SYSTOLIC = 3'd3,
    DM_WIDE     = 3'd4
  } dm_mode_e;

  typedef struct packed {
    logic [DM_WD_W-1:0] ax;
    logic [DM_WD_W-1:0] ay;
    logic [DM_XN_W-1:0] bx;
    logic [DM_YN_W-1:0] by;
    logic               sub;
  } dm_ops_t;

  // Width of the x operand that is actually used.
  function automatic int dm_x_width(input bit wide);
    return wide ? DM_WD_W : DM_XN_W;
  endfunction

  // Width of the y operand that is actually used.
  function automatic int dm_y_width(input bit wide, input bit is_signed);
    if (wide) return DM_WD_W;
    return is_signed ? DM_YN_W : DM_YU_W;
  endfunction

  // Keep the low used_w bits and fill the rest with the sign or with zero.
  function automatic logic signed [DM_ACC_W-1:0] dm_extend(
      input logic [DM_ADD_W-1:0] raw, input int used_w, input bit is_signed);
    logic signed [DM_ACC_W-1:0] r;
    logic fill;
    fill = is_signed & raw[used_w-1];
    for (int i = 0; i < DM_ADD_W; i++) r[i] = (i < used_w) ? raw[i] : fill;
    for (int i = DM_ADD_W; i < DM_ACC_W; i++) r[i] = fill;
    return r;
  endfunction

  function automatic logic signed [DM_ACC_W-1:0] dm_product(
      input logic signed [DM_ACC_W-1:0] a, input logic signed [DM_ACC_W-1:0] b);
    return a * b;
  endfunction

  // Join the two bottom buses into one addend, high half from x.
  function automatic logic signed [DM_ACC_W-1:0] dm_join_addend(
      input logic [DM_XN_W-1:0] hi, input logic [DM_YU_W-1:0] lo, input bit is_signed);
    return dm_extend({hi, lo}, DM_ADD_W, is_signed);
  endfunction

  function automatic logic signed [DM_ACC_W-1:0] dm_apply_sign(
      input logic signed [DM_ACC_W-1:0] p, input logic neg);
    return neg ? -p : p;
  endfunction

endpackage

// File: rtl/dmadd_in_stage.sv
module dmadd_in_stage
  import dmadd_pkg::*;
#(
  parameter bit SYSTOLIC = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dm_ops_t            ops_i,
  output logic [DM_WD_W-1:0] top_x_o,
  output logic [DM_WD_W-1:0] top_y_o,
  output logic [DM_XN_W-1:0] bot_x_o,
  output logic [DM_YN_W-1:0] bot_y_o,
  output logic               sub_o
);

  dm_ops_t cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else        cap_q <= ops_i;
  end

  assign bot_x_o = cap_q.bx;
  assign bot_y_o = cap_q.by;
  assign sub_o   = cap_q.sub;

  generate
    if (SYSTOLIC) begin : g_sys
      logic [DM_WD_W-1:0] sys_x_q, sys_y_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sys_x_q <= '0;
          sys_y_q <= '0;
        end else begin
          sys_x_q <= cap_q.ax;
          sys_y_q <= cap_q.ay;
        end
      end
      assign top_x_o = sys_x_q;
      assign top_y_o = sys_y_q;
    end else begin : g_direct
      assign top_x_o = cap_q.ax;
      assign top_y_o = cap_q.ay;
    end
  endgenerate

  // R1: the control leaves reset low
  p_sub_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sub_o == 1'b0));

endmodule

// File: rtl/dmadd_mult.sv
module dmadd_mult
  import dmadd_pkg::*;
#(
  parameter dm_mode_e MODE      = DM_INDEP,
  parameter bit       AX_SIGNED = 1'b1,
  parameter bit       AY_SIGNED = 1'b1,
  parameter bit       BX_SIGNED = 1'b1,
  parameter bit       BY_SIGNED = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [DM_WD_W-1:0]         top_x,
  input  logic [DM_WD_W-1:0]         top_y,
  input  logic [DM_XN_W-1:0]         bot_x,
  input  logic [DM_YN_W-1:0]         bot_y,
  output logic signed [DM_ACC_W-1:0] top_prod,
  output logic signed [DM_ACC_W-1:0] bot_prod,
  output logic signed [DM_ACC_W-1:0] addend
);

  localparam bit WIDE    = (MODE == DM_WIDE);
  localparam bit USE_BOT = (MODE == DM_INDEP) || (MODE == DM_SUM2) || (MODE == DM_SYSTOLIC);
  localparam bit USE_ADD = (MODE == DM_PLUS36);
  localparam int TX_W    = dm_x_width(WIDE);
  localparam int TY_W    = dm_y_width(WIDE, AY_SIGNED);
  localparam int BX_W    = dm_x_width(1'b0);
  localparam int BY_W    = dm_y_width(1'b0, BY_SIGNED);

  logic signed [DM_ACC_W-1:0] tx_ext, ty_ext, bx_ext, by_ext;

  always_comb begin
    tx_ext   = dm_extend(DM_ADD_W'(top_x), TX_W, AX_SIGNED);
    ty_ext   = dm_extend(DM_ADD_W'(top_y), TY_W, AY_SIGNED);
    bx_ext   = dm_extend(DM_ADD_W'(bot_x), BX_W, BX_SIGNED);
    by_ext   = dm_extend(DM_ADD_W'(bot_y), BY_W, BY_SIGNED);
    top_prod = dm_product(tx_ext, ty_ext);
    bot_prod = USE_BOT ? dm_product(bx_ext, by_ext) : '0;
    addend   = USE_ADD ? dm_join_addend(bot_x, bot_y[DM_YU_W-1:0], BX_SIGNED) : '0;
  end

  // R5: a zero factor always yields a zero top product
  p_zero_factor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((top_x == '0) || (top_y == '0)) |-> (top_prod == '0));

endmodule

// File: rtl/dmadd_combine.sv
module dmadd_combine
  import dmadd_pkg::*;
#(
  parameter dm_mode_e MODE = DM_INDEP,
  parameter int       RA_W = 64,
  parameter int       RB_W = 37
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic signed [DM_ACC_W-1:0] top_prod,
  input  logic signed [DM_ACC_W-1:0] bot_prod,
  input  logic signed [DM_ACC_W-1:0] addend,
  input  logic                       sub,
  output logic [RA_W-1:0]            resulta,
  output logic [RB_W-1:0]            resultb
);

  logic signed [DM_ACC_W-1:0] a_next, b_next;

  always_comb begin
    a_next = '0;
    b_next = '0;
    case (MODE)
      DM_INDEP: begin
        a_next = top_prod;
        b_next = bot_prod;
      end
      DM_SUM2, DM_SYSTOLIC: a_next = dm_apply_sign(top_prod, sub) + bot_prod;
      DM_PLUS36:            a_next = top_prod + addend;
      default:              a_next = top_prod;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resulta <= '0;
      resultb <= '0;
    end else begin
      resulta <= RA_W'(a_next);
      resultb <= RB_W'(b_next);
    end
  end

  generate
    if (MODE != DM_INDEP) begin : g_b_quiet
      // R4: the second output carries nothing outside independent mode
      p_b_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        resultb == '0);
    end
  endgenerate

endmodule

// File: rtl/dmadd_unit.sv
module dmadd_unit
  import dmadd_pkg::*;
#(
  parameter dm_mode_e MODE      = DM_INDEP,
  parameter bit       AX_SIGNED = 1'b1,
  parameter bit       AY_SIGNED = 1'b1,
  parameter bit       BX_SIGNED = 1'b1,
  parameter bit       BY_SIGNED = 1'b1,
  parameter int       RA_W      = 64,
  parameter int       RB_W      = 37
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DM_WD_W-1:0] ax,
  input  logic [DM_WD_W-1:0] ay,
  input  logic [DM_XN_W-1:0] bx,
  input  logic [DM_YN_W-1:0] by,
  input  logic               sub,
  output logic [RA_W-1:0]    resulta,
  output logic [RB_W-1:0]    resultb
);

  localparam bit SYSTOLIC = (MODE == DM_SYSTOLIC);

  dm_ops_t ops;
  logic [DM_WD_W-1:0] top_x, top_y;
  logic [DM_XN_W-1:0] bot_x;
  logic [DM_YN_W-1:0] bot_y;
  logic               sub_q;
  logic signed [DM_ACC_W-1:0] top_prod, bot_prod, addend;

  assign ops = '{ax: ax, ay: ay, bx: bx, by: by, sub: sub};

  dmadd_in_stage #(.SYSTOLIC(SYSTOLIC)) u_in (
    .clk(clk), .rst_n(rst_n), .ops_i(ops),
    .top_x_o(top_x), .top_y_o(top_y), .bot_x_o(bot_x), .bot_y_o(bot_y), .sub_o(sub_q)
  );

  dmadd_mult #(
    .MODE(MODE), .AX_SIGNED(AX_SIGNED), .AY_SIGNED(AY_SIGNED),
    .BX_SIGNED(BX_SIGNED), .BY_SIGNED(BY_SIGNED)
  ) u_mult (
    .clk(clk), .rst_n(rst_n),
    .top_x(top_x), .top_y(top_y), .bot_x(bot_x), .bot_y(bot_y),
    .top_prod(top_prod), .bot_prod(bot_prod), .addend(addend)
  );

  dmadd_combine #(.MODE(MODE), .RA_W(RA_W), .RB_W(RB_W)) u_comb (
    .clk(clk), .rst_n(rst_n),
    .top_prod(top_prod), .bot_prod(bot_prod), .addend(addend), .sub(sub_q),
    .resulta(resulta), .resultb(resultb)
  );

  // Observation logic for the hold property: input history since reset.
  dm_ops_t    prev_ops;
  logic       same_q1, same_q2;
  logic [1:0] warm;
  logic       same_now;

  assign same_now = (ops == prev_ops);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ops <= '0;
      same_q1  <= 1'b0;
      same_q2  <= 1'b0;
      warm     <= '0;
    end else begin
      prev_ops <= ops;
      same_q1  <= same_now;
      same_q2  <= same_q1;
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  // R9: four equal input samples in a row keep both outputs unchanged
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((warm == 2'd3) && same_now && same_q1 && same_q2) |=> ($stable(resulta) && $stable(resultb)));

  generate
    if ((MODE == DM_INDEP) && !BX_SIGNED && !BY_SIGNED && (RB_W > 36)) begin : g_umsb
      // R2: an unsigned 18x18 product never reaches the top bit of the second output
      p_unsigned_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        resultb[RB_W-1] == 1'b0);
    end
  endgenerate

endmodule

// File: tb/dmadd_unit_bench.sv
`timescale 1ns/1ps
module dmadd_unit_bench;
  import dmadd_pkg::*;

  localparam int NI = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [26:0] ax, ay;
  logic [17:0] bx;
  logic [18:0] by;
  logic        sub;
  logic [63:0] ra [NI];
  logic [36:0] rb [NI];

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  dmadd_unit #(.MODE(DM_INDEP), .AX_SIGNED(1'b1), .AY_SIGNED(1'b1), .BX_SIGNED(1'b1), .BY_SIGNED(1'b1))
    u_dmadd_unit (.clk(clk), .rst_n(rst_n), .ax(ax), .ay(ay), .bx(bx), .by(by), .sub(sub), .resulta(ra[0]), .resultb(rb[0]));
  dmadd_unit #(.MODE(DM_INDEP), .AX_SIGNED(1'b0), .AY_SIGNED(1'b0), .BX_SIGNED(1'b0), .BY_SIGNED(1'b0))
    u_indep_u (.clk(clk), .rst_n(rst_n), .ax(ax), .ay(ay), .bx(bx), .by(by), .sub(sub), .resulta(ra[1]), .resultb(rb[1]));
  dmadd_unit #(.MODE(DM_SUM2), .AX_SIGNED(1'b1), .AY_SIGNED(1'b0), .BX_SIGNED(1'b0), .BY_SIGNED(1'b1))
    u_sum (.clk(clk), .rst_n(rst_n), .ax(ax), .ay(ay), .bx(bx), .by(by), .sub(sub), .resulta(ra[2]), .resultb(rb[2]));
  dmadd_unit #(.MODE(DM_PLUS36), .AX_SIGNED(1'b1), .AY_SIGNED(1'b1), .BX_SIGNED(1'b1), .BY_SIGNED(1'b0))
    u_p36 (.clk(clk), .rst_n(rst_n), .ax(ax), .ay(ay), .bx(bx), .by(by), .sub(sub), .resulta(ra[3]), .resultb(rb[3]));
  dmadd_unit #(.MODE(DM_SYSTOLIC), .AX_SIGNED(1'b1), .AY_SIGNED(1'b1), .BX_SIGNED(1'b1), .BY_SIGNED(1'b1))
    u_sys (.clk(clk), .rst_n(rst_n), .ax(ax), .ay(ay), .bx(bx), .by(by), .sub(sub), .resulta(ra[4]), .resultb(rb[4]));
  dmadd_unit #(.MODE(DM_WIDE), .AX_SIGNED(1'b0), .AY_SIGNED(1'b1), .BX_SIGNED(1'b1), .BY_SIGNED(1'b1))
    u_wide (.clk(clk), .rst_n(rst_n), .ax(ax), .ay(ay), .bx(bx), .by(by), .sub(sub), .resulta(ra[5]), .resultb(rb[5]));

  // Reference model: sampled inputs per clock edge, newest first.
  typedef struct {
    longint ax, ay, bx, by;
    bit     sub;
  } smp_t;
  smp_t hist[$];

  // Independent sign handling: mask to the width, subtract 2^w when negative.
  function automatic longint ext(longint v, int w, bit s);
    longint m = (longint'(1) <<< w) - 1;
    longint r = v & m;
    if (s && (((r >>> (w - 1)) & 1) == 1)) r = r - (longint'(1) <<< w);
    return r;
  endfunction

  function automatic longint top_small(smp_t c, bit xs, bit ys);
    return ext(c.ax, 18, xs) * ext(c.ay, ys ? 19 : 18, ys);
  endfunction

  function automatic longint bottom(smp_t c, bit xs, bit ys);
    return ext(c.bx, 18, xs) * ext(c.by, ys ? 19 : 18, ys);
  endfunction

  function automatic longint exp_a(int k, smp_t c, smp_t o);
    case (k)
      0: return top_small(c, 1, 1);
      1: return top_small(c, 0, 0);
      2: return bottom(c, 0, 1) + (c.sub ? -top_small(c, 1, 0) : top_small(c, 1, 0));
      3: return top_small(c, 1, 1) + ext((c.bx <<< 18) | (c.by & 'h3FFFF), 36, 1);
      4: return bottom(c, 1, 1) + (c.sub ? -top_small(o, 1, 1) : top_small(o, 1, 1));
      default: return ext(c.ax, 27, 0) * ext(c.ay, 27, 1);
    endcase
  endfunction

  function automatic longint exp_b(int k, smp_t c);
    if (k == 0) return bottom(c, 1, 1);
    if (k == 1) return bottom(c, 0, 0);
    return 0;
  endfunction

  function automatic string tag_of(int k);
    case (k)
      0: return "R2";
      1: return "R5";
      2: return "R3";
      3: return "R6";
      4: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  initial begin
    smp_t z;
    z = '{0, 0, 0, 0, 1'b0};
    repeat (3) hist.push_front(z);
  end

  always @(posedge clk) begin
    smp_t s;
    if (rst_n === 1'b1) s = '{longint'(ax), longint'(ay), longint'(bx), longint'(by), sub};
    else                s = '{0, 0, 0, 0, 1'b0};
    hist.push_front(s);
    if (hist.size() > 4) void'(hist.pop_back());
  end

  // Compare every clock, away from the active edge. R9: expectation uses
  // the inputs sampled one edge before the last (two-cycle latency).
  always @(negedge clk) begin
    if (rst_n !== 1'b1) begin
      for (int k = 0; k < NI; k++) begin
        chk("R1", ra[k], 64'd0);
        chk("R1", 64'(rb[k]), 64'd0);
      end
    end else begin
      for (int k = 0; k < NI; k++) begin
        chk(tag_of(k), ra[k], 64'(exp_a(k, hist[1], hist[2])));
        if (k < 2) chk(tag_of(k), 64'(rb[k]), 64'(exp_b(k, hist[1]) & ((longint'(1) <<< 37) - 1)));
        else       chk("R4", 64'(rb[k]), 64'd0);
      end
    end
  end

  task automatic drive(logic [26:0] a_x, logic [26:0] a_y, logic [17:0] b_x, logic [18:0] b_y, logic s);
    @(posedge clk);
    #1;
    ax = a_x; ay = a_y; bx = b_x; by = b_y; sub = s;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9: watchdog got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    ax = '0; ay = '0; bx = '0; by = '0; sub = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // boundary patterns (R2, R3, R5, R8)
    drive('0, '0, '0, '0, 1'b0);
    drive('1, '1, '1, '1, 1'b0);
    drive('1, '1, '1, '1, 1'b1);
    drive(27'h001FFFF, 27'h003FFFF, 18'h1FFFF, 19'h3FFFF, 1'b0);
    drive(27'h0020000, 27'h0040000, 18'h20000, 19'h40000, 1'b1);
    drive(27'h7FC0001, 27'h7F80003, 18'h00005, 19'h40007, 1'b0);
    drive(27'h4000000, 27'h4000000, 18'h3FFFF, 19'h7FFFF, 1'b1);
    drive(27'h3FFFFFF, 27'h3FFFFFF, 18'h00001, 19'h00001, 1'b0);
    // R6: narrow addend supplied sign-extended, by[18] and sub set as noise
    drive(27'h0, 27'h5, 18'h3FFFF, {1'b1, 18'h3FAAA}, 1'b1);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R6", ra[3], 64'(-64'sd1366));
    // random operands with sub toggling (R3, R7 skew)
    for (int i = 0; i < 500; i++)
      drive(27'($urandom()), 27'($urandom()), 18'($urandom()), 19'($urandom()), 1'($urandom()));
    // mid-run reset (R1)
    @(posedge clk);
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < 300; i++)
      drive(27'($urandom()), 27'($urandom()), 18'($urandom()), 19'($urandom()), 1'(i % 2));
    drive('0, '0, '0, '0, 1'b0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule